// File: doc/BRIEF.md
# Blocking Counting Semaphore Cell

This block is a single storage cell for synchronising threads. It holds a saturating counter that requesters take from and give to through one request port. Each access carries a 4-bit view code that selects the behaviour. The wait view and the poll view both act as semaphore views: a read takes a unit and a write gives one. A read in the wait view that finds the counter at zero stalls the requester and records it in a bitmap. The next give releases every recorded requester with a one-cycle wake pulse.

Read data and the stall flag are combinational: they reflect the cell state and the request in the same cycle. All state changes take effect at the next rising clock edge. The wake vector is registered and appears in the cycle after the releasing give. Other view codes give raw access, access to the tag bits, or no effect. This way the cell fits into a map shared with queue-type cells.

Top module: `sem_cell`

## Requirements
- R1: After reset the counter is zero, no requester is recorded, the tag bits T, F and E are zero and `wake_o` is zero.
- R2: A read with view 4 (wait) or view 5 (poll) returns the counter value from before the access, zero-extended. If that value is non-zero, the counter decrements by one at the next edge.
- R3: A read with view 4 while the counter is zero asserts `stall_o` and returns 0. The counter is left unchanged and the requester `req_id` is recorded for wake-up.
- R4: A read with view 5 while the counter is zero returns 0, does not stall, and records nothing.
- R5: A write with view 4 or 5 ignores `req_wdata` and increments the counter. At the maximum value (0xFFFF with the default 16-bit count) the counter stays at that value.
- R6: A write with view 4 or 5 while requesters are recorded drives `wake_o`, one cycle later and for exactly one cycle, with the bitmap of recorded requesters (bit i = requester id i). It then clears the bitmap, so a following give produces no wake.
- R7: View 0 (raw) reads return the counter without changing it. View 0 writes have no effect.
- R8: Views 2 and 3 (queue views) read as 0, and their writes have no effect.
- R9: A view 1 (tag) read returns T in bit 16, F in bit 1 and E in bit 0, with all other bits zero; bit 17, the queue flag, is always 0. A view 1 write loads T, F and E from those same data bits.
- R10: Views 6 to 15 read as all ones and have no effect.
- R11: `stall_o` is high only for a view 4 read while the counter is zero, and `rdata_o` is 0 when `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write (give / load), 0 = read (take) |
| req_view | input | 4 | View code selecting the access behaviour |
| req_id | input | 3 | Identity of the requester |
| req_wdata | input | 32 | Write data (used by the tag view only) |
| rdata_o | output | 32 | Read data, same cycle |
| stall_o | output | 1 | Requester must stall; it has been recorded |
| wake_o | output | 8 | One-cycle pulse of released requesters |

## Verification
A counter that is off by one shows on the very next take or raw read, because every read returns the full count. A wrong saturation shows on the first give at the top value. A lost or stale waiter bit shows only when the next give arrives: the wake vector one cycle later then has a missing or extra bit, or a second give wakes requesters again. The reference model is compared on every cycle, including idle ones. A wake pulse that lasts too long, or that fires without a give, is therefore seen in the cycle where it happens.

// File: rtl/sem_pkg.sv
// Package: shared view codes and tag bit positions for the semaphore cell.
// Assumes a 4-bit view field; positions are fixed by the shared tag layout.
package sem_pkg;
    typedef enum logic [3:0] {
        VIEW_RAW      = 4'd0,
        VIEW_TAG      = 4'd1,
        VIEW_Q_WAIT   = 4'd2,
        VIEW_Q_POLL   = 4'd3,
        VIEW_SEM_WAIT = 4'd4,
        VIEW_SEM_POLL = 4'd5
    } view_e;

    localparam int TAG_E_POS = 0;
    localparam int TAG_F_POS = 1;
    localparam int TAG_T_POS = 16;
    localparam int TAG_Q_POS = 17;

    typedef struct packed {
        logic t;
        logic f;
        logic e;
    } tag_t;
endpackage

// File: rtl/sem_count.sv
// Saturating up/down counter of the semaphore.
// Assumes inc and dec are never high together (single request port).
module sem_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Counter update: saturate at top, floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
    // R5
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sem_waitlist.sv
// Records blocked requesters and releases all of them on a give.
// Assumes add and release are never high together.
module sem_waitlist #(
    parameter int NREQ = 8,
    localparam int ID_W = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add,
    input  logic [ID_W-1:0] add_id,
    input  logic            release_all,
    output logic [NREQ-1:0] wake
);
    logic [NREQ-1:0] waiters;

    // Waiter bitmap: set on a blocked take, cleared on a give.
    always_ff @(posedge clk) begin
        if (!rst_n)
            waiters <= '0;
        else if (release_all)
            waiters <= '0;
        else if (add)
            waiters <= waiters | (NREQ'(1) << add_id);
    end

    // Wake pulse: one cycle, only when a give finds waiters.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake <= '0;
        else
            wake <= (release_all && |waiters) ? waiters : '0;
    end

    // R6
    wake_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_all && |waiters) |=> (wake == $past(waiters)));
    // R6
    list_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_all |=> (waiters == '0));
    // R3
    add_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add |=> waiters[$past(add_id)]);
endmodule

// File: rtl/sem_cell.sv
// Top: decodes the view of each request and drives the counter, the waiter
// list and the tag bits. Read data and stall are combinational.
// Assumes at most one request per cycle and DATA_W > 17.
module sem_cell #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int NREQ   = 8,
    localparam int ID_W  = $clog2(NREQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_view,
    input  logic [ID_W-1:0]   req_id,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata_o,
    output logic              stall_o,
    output logic [NREQ-1:0]   wake_o
);
    import sem_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic             sem_view, take, give, dec, block, tag_wr;
    tag_t             tag;

    // Request classification.
    always_comb begin
        sem_view = (req_view == VIEW_SEM_WAIT) || (req_view == VIEW_SEM_POLL);
        take     = req_valid && !req_write && sem_view;
        give     = req_valid &&  req_write && sem_view;
        dec      = take && cnt != '0;
        block    = req_valid && !req_write && req_view == VIEW_SEM_WAIT && cnt == '0;
        tag_wr   = req_valid &&  req_write && req_view == VIEW_TAG;
    end

    sem_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(give), .dec(dec), .cnt(cnt)
    );

    sem_waitlist #(.NREQ(NREQ)) u_wait (
        .clk(clk), .rst_n(rst_n), .add(block), .add_id(req_id),
        .release_all(give), .wake(wake_o)
    );

    // Tag bits: loaded by a tag-view write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag <= '0;
        else if (tag_wr)
            tag <= '{t: req_wdata[TAG_T_POS], f: req_wdata[TAG_F_POS],
                     e: req_wdata[TAG_E_POS]};
    end

    // Read data mux by view.
    always_comb begin
        rdata_o = '0;
        if (req_valid && !req_write) begin
            case (req_view)
                VIEW_RAW, VIEW_SEM_WAIT, VIEW_SEM_POLL:
                    rdata_o = DATA_W'(cnt);
                VIEW_TAG: begin
                    rdata_o[TAG_T_POS] = tag.t;
                    rdata_o[TAG_F_POS] = tag.f;
                    rdata_o[TAG_E_POS] = tag.e;
                    rdata_o[TAG_Q_POS] = 1'b0;
                end
                VIEW_Q_WAIT, VIEW_Q_POLL:
                    rdata_o = '0;
                default:
                    rdata_o = '1;
            endcase
        end
    end

    assign stall_o = block;

    // R11
    stall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (cnt == '0 && rdata_o == '0));
    // R11
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (rdata_o == '0 && !stall_o));
endmodule

// File: tb/sem_cell_bench.sv
module sem_cell_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_view = '0;
    logic [2:0]  req_id = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rdata_o;
    logic        stall_o;
    logic [7:0]  wake_o;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // Reference model state.
    int       m_cnt = 0;
    bit [7:0] m_map = '0, m_wake = '0;
    bit       m_t = 0, m_f = 0, m_e = 0;

    sem_cell u_sem_cell (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
        .rdata_o(rdata_o), .stall_o(stall_o), .wake_o(wake_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One access: drive, compare at negedge, then advance the model at the edge.
    task automatic op(input bit v, input bit w, input int vw, input int id,
                      input int data, input string rq);
        longint er;
        bit     es;
        req_valid = v; req_write = w; req_view = 4'(vw);
        req_id = 3'(id); req_wdata = data;
        er = 0; es = 0;
        if (v && !w) begin
            case (vw)
                0, 4, 5: er = m_cnt;
                1: er = (longint'(m_t) << 16) | (longint'(m_f) << 1) | longint'(m_e);
                2, 3: er = 0;
                default: er = 32'hFFFF_FFFF;
            endcase
            if (vw == 4 && m_cnt == 0) es = 1;
        end
        @(negedge clk);
        chk(rq, "rdata", rdata_o, er);
        chk(rq, "stall", stall_o, es);
        chk("R6", "wake", wake_o, m_wake);
        @(posedge clk);
        m_wake = '0;
        if (v && w && (vw == 4 || vw == 5)) begin
            m_wake = m_map;
            m_map = '0;
            if (m_cnt < 65535) m_cnt++;
        end else if (v && !w && (vw == 4 || vw == 5)) begin
            if (m_cnt > 0) m_cnt--;
            else if (vw == 4) m_map[id] = 1'b1;
        end else if (v && w && vw == 1) begin
            m_t = data[16]; m_f = data[1]; m_e = data[0];
        end
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        op(1, 0, 0, 0, 0, "R1");
        op(1, 0, 1, 0, 0, "R1");
        op(0, 0, 0, 0, 0, "R11");
        // R4 poll take on zero
        op(1, 0, 5, 3, 0, "R4");
        op(1, 1, 4, 0, 0, "R4");   // give: no waiters expected
        op(0, 0, 0, 0, 0, "R6");
        op(1, 0, 5, 0, 0, "R2");
        // R3 blocking takes on zero
        op(1, 0, 4, 2, 0, "R3");
        op(1, 0, 4, 5, 0, "R3");
        op(1, 0, 0, 0, 0, "R3");
        op(1, 1, 5, 0, 32'hDEAD_BEEF, "R6");
        op(0, 0, 0, 0, 0, "R6");
        op(1, 1, 4, 0, 0, "R6");
        op(0, 0, 0, 0, 0, "R6");
        // R5 gives, R2 takes
        op(1, 1, 4, 0, 32'h1234, "R5");
        op(1, 1, 5, 0, 0, "R5");
        op(1, 0, 4, 1, 0, "R2");
        op(1, 0, 5, 1, 0, "R2");
        op(1, 0, 4, 7, 0, "R2");
        // R7 raw view
        op(1, 1, 0, 0, 77, "R7");
        op(1, 0, 0, 0, 0, "R7");
        op(1, 0, 0, 0, 0, "R7");
        // R8 queue views
        op(1, 1, 2, 0, 5, "R8");
        op(1, 1, 3, 0, 5, "R8");
        op(1, 0, 2, 0, 0, "R8");
        op(1, 0, 3, 0, 0, "R8");
        op(1, 0, 0, 0, 0, "R8");
        // R9 tag view
        op(1, 1, 1, 0, 32'hFFFF_FFFF, "R9");
        op(1, 0, 1, 0, 0, "R9");
        op(1, 1, 1, 0, 32'h0000_0002, "R9");
        op(1, 0, 1, 0, 0, "R9");
        // R10 unused views
        for (int k = 6; k < 16; k++) op(1, 0, k, 0, 0, "R10");
        op(1, 1, 9, 0, 1, "R10");
        op(1, 0, 0, 0, 0, "R10");
        // R5 saturation
        for (int k = 0; k < 65540; k++) op(1, 1, 5, 0, 0, "R5");
        op(1, 0, 0, 0, 0, "R5");
        op(1, 0, 5, 0, 0, "R5");
        op(1, 1, 4, 0, 0, "R5");
        op(1, 0, 0, 0, 0, "R5");
        op(0, 0, 0, 0, 0, "R11");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule